// File: doc/BRIEF.md
# Multi-mode up/down position counter

This block keeps a position count that moves by one on each accepted count strobe, up or down as the direction input says. A host configures it through a parallel write port with three addresses: a count-behaviour register, a width-and-flags register and a data value. The data value is the preload source and also the limit or modulus. The count can wrap freely, stop after one wrap, stay inside a range, or run modulo the data value. Its width can be set at run time to one, two, three or four bytes.

An index input can load the count from the data value, clear it, or copy it into a snapshot register. The host can do the same through command strobes. Four sticky status bits record carry, borrow, compare and index events. Four enable bits pick which of these status bits drive a single flag output. The quadrature decoder and any serial host link sit outside this block. Reset is asynchronous active-low. It is expected to be released in step with the clock by the reset logic upstream.

Top module: `updn_pos_counter`

## Requirements
- R1: After reset, `cnt_o`, `otr_o` and `status_o` are zero, `flag_o` is low, and all configuration registers (both mode registers and the data value) hold zero.
- R2: Behaviour code 00 (address 0, bits [1:0]) runs freely. An up step from the top of the selected width gives 0 and sets carry (status bit 3). A down step from 0 gives the top value and sets borrow (status bit 2). Any other step moves the count by one.
- R3: Behaviour code 01 works like code 00 until a step raises carry or borrow. After that, count strobes are ignored until a host reset or load, or an index load or clear.
- R4: Behaviour code 10 holds the count between 0 and the data value. An up step at or above the data value leaves the count unchanged and sets carry. A down step at 0 leaves it unchanged and sets borrow. A step in the opposite direction moves the count again.
- R5: Behaviour code 11 runs modulo (data value + 1). An up step at or above the data value gives 0 and sets carry. A down step at 0 gives the data value and sets borrow.
- R6: The width code (address 1, bits [1:0]) selects the width: 00 is 4 bytes, 01 is 3, 10 is 2 and 11 is 1. `cnt_o` shows only the selected bytes, and wrapping, carry and borrow follow that width.
- R7: When the inhibit bit (address 1, bit 2) is 1, count strobes have no effect.
- R8: The index action (address 0, bits [3:2]) sets what an index pulse does: 00 nothing, 01 loads the data value into the count, 10 clears the count, 11 copies the count into `otr_o`. Any action other than 00 also sets the index status bit (bit 0).
- R9: A count step that changes the count to a value equal to the data value sets the compare status bit (bit 1).
- R10: Status bits stay set until `stat_clr_i` is pulsed. If an event arrives in the same cycle as the clear, the event's bit is left set.
- R11: `flag_o` is high when any status bit is set whose enable is 1. The enables are at address 1: bit 3 for index, bit 4 for compare, bit 5 for borrow and bit 6 for carry.
- R12: On the count, host reset wins over host load. Host load wins over an index load or clear, and an index load or clear wins over a count strobe. A snapshot, from the host or from the index, copies the count value from before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cnt_en_i | input | 1 | Count strobe, one step per cycle high |
| cnt_up_i | input | 1 | Step direction: 1 up, 0 down |
| index_i | input | 1 | Index event, acted on in each cycle it is high |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 2 | Write address: 0 behaviour/index, 1 width/inhibit/enables, 2 data value |
| wr_data_i | input | CW | Write data |
| host_rst_i | input | 1 | Host command: clear the count |
| host_load_i | input | 1 | Host command: load the data value into the count |
| host_latch_i | input | 1 | Host command: copy the count to the snapshot |
| stat_clr_i | input | 1 | Clear all status bits |
| cnt_o | output | CW | Count at the selected width |
| otr_o | output | CW | Snapshot register |
| status_o | output | 4 | Status: [3] carry, [2] borrow, [1] compare, [0] index |
| flag_o | output | 1 | Enabled-event flag |

## Verification
Every strobe, command and write is sampled on one rising edge. `cnt_o`, `otr_o` and `status_o` change on that same edge. `flag_o` follows the status and enable registers with no added cycle, so every result is due one edge after its stimulus. The bench drives inputs just after a falling edge and removes them at the next falling edge. It compares all four outputs at that moment, half a period after the edge that should have updated them. A configuration write takes effect at its own edge, so a strobe in the following cycle already sees the new behaviour, width or limit.

// File: rtl/updn_pos_pkg.sv
package updn_pos_pkg;

  typedef enum logic [1:0] {
    CM_FREE   = 2'b00,
    CM_SINGLE = 2'b01,
    CM_RANGE  = 2'b10,
    CM_MODULO = 2'b11
  } cnt_mode_e;

  typedef enum logic [1:0] {
    IX_NONE  = 2'b00,
    IX_LOAD  = 2'b01,
    IX_CLEAR = 2'b10,
    IX_LATCH = 2'b11
  } idx_act_e;

  typedef enum logic [1:0] {
    W_4B = 2'b00,
    W_3B = 2'b01,
    W_2B = 2'b10,
    W_1B = 2'b11
  } width_e;

  // address 0: [3:2] index action, [1:0] behaviour
  typedef struct packed {
    idx_act_e  idx_act;
    cnt_mode_e mode;
  } mode_a_t;

  // address 1: [6] carry en, [5] borrow en, [4] compare en, [3] index en,
  // [2] inhibit, [1:0] width
  typedef struct packed {
    logic   en_cy;
    logic   en_bw;
    logic   en_cmp;
    logic   en_idx;
    logic   inhibit;
    width_e width;
  } mode_b_t;

  localparam int MODE_A_W = $bits(mode_a_t);
  localparam int MODE_B_W = $bits(mode_b_t);

  localparam int ST_IDX = 0;
  localparam int ST_CMP = 1;
  localparam int ST_BW  = 2;
  localparam int ST_CY  = 3;
  localparam int ST_W   = 4;

  localparam logic [1:0] ADDR_MODE_A = 2'd0;
  localparam logic [1:0] ADDR_MODE_B = 2'd1;
  localparam logic [1:0] ADDR_DATA   = 2'd2;

endpackage

// File: rtl/updn_pos_regs.sv
module updn_pos_regs
  import updn_pos_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [CW-1:0] wr_data_i,
  output mode_a_t       mode_a_o,
  output mode_b_t       mode_b_o,
  output logic [CW-1:0] data_o
);

  mode_a_t       mode_a_q, mode_a_d;
  mode_b_t       mode_b_q, mode_b_d;
  logic [CW-1:0] data_q, data_d;
  logic          we_a, we_b, we_data;

  always_comb begin
    we_a     = wr_en_i && (wr_addr_i == ADDR_MODE_A);
    we_b     = wr_en_i && (wr_addr_i == ADDR_MODE_B);
    we_data  = wr_en_i && (wr_addr_i == ADDR_DATA);
    mode_a_d = mode_a_t'(wr_data_i[MODE_A_W-1:0]);
    mode_b_d = mode_b_t'(wr_data_i[MODE_B_W-1:0]);
    data_d   = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_a_q <= '0;
      mode_b_q <= '0;
      data_q   <= '0;
    end else begin
      if (we_a)    mode_a_q <= mode_a_d;
      if (we_b)    mode_b_q <= mode_b_d;
      if (we_data) data_q   <= data_d;
    end
  end

  assign mode_a_o = mode_a_q;
  assign mode_b_o = mode_b_q;
  assign data_o   = data_q;

endmodule

// File: rtl/updn_pos_mask.sv
module updn_pos_mask
  import updn_pos_pkg::*;
#(
  parameter int NBYTES = 4
) (
  input  width_e              width_i,
  output logic [8*NBYTES-1:0] mask_o
);

  logic [2:0] sel_bytes;

  always_comb begin
    case (width_i)
      W_4B:    sel_bytes = 3'd4;
      W_3B:    sel_bytes = 3'd3;
      W_2B:    sel_bytes = 3'd2;
      default: sel_bytes = 3'd1;
    endcase
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign mask_o[b*8 +: 8] = (3'(b) < sel_bytes) ? 8'hFF : 8'h00;
  end

endmodule

// File: rtl/updn_pos_step.sv
module updn_pos_step
  import updn_pos_pkg::*;
#(
  parameter int CW = 32
) (
  input  cnt_mode_e     mode_i,
  input  logic          up_i,
  input  logic [CW-1:0] cur_i,
  input  logic [CW-1:0] limit_i,
  input  logic [CW-1:0] top_i,
  output logic [CW-1:0] nxt_o,
  output logic          carry_o,
  output logic          borrow_o
);

  logic at_top, at_zero, at_limit;

  always_comb begin
    at_top   = (cur_i == top_i);
    at_zero  = (cur_i == '0);
    at_limit = (cur_i >= limit_i);
    nxt_o    = cur_i;
    carry_o  = 1'b0;
    borrow_o = 1'b0;
    case (mode_i)
      CM_RANGE: begin
        if (up_i) begin
          if (at_limit) carry_o = 1'b1;
          else          nxt_o   = cur_i + 1'b1;
        end else begin
          if (at_zero)  borrow_o = 1'b1;
          else          nxt_o    = cur_i - 1'b1;
        end
      end
      CM_MODULO: begin
        if (up_i) begin
          if (at_limit) begin
            nxt_o   = '0;
            carry_o = 1'b1;
          end else begin
            nxt_o   = cur_i + 1'b1;
          end
        end else begin
          if (at_zero) begin
            nxt_o    = limit_i;
            borrow_o = 1'b1;
          end else begin
            nxt_o    = cur_i - 1'b1;
          end
        end
      end
      default: begin
        if (up_i) begin
          if (at_top) begin
            nxt_o   = '0;
            carry_o = 1'b1;
          end else begin
            nxt_o   = cur_i + 1'b1;
          end
        end else begin
          if (at_zero) begin
            nxt_o    = top_i;
            borrow_o = 1'b1;
          end else begin
            nxt_o    = cur_i - 1'b1;
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/updn_pos_status.sv
module updn_pos_status
  import updn_pos_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ST_W-1:0] set_i,
  input  logic            clr_i,
  output logic [ST_W-1:0] status_o
);

  logic [ST_W-1:0] st_q, st_d;
  logic            st_ce;

  always_comb begin
    st_ce = clr_i || (set_i != '0);
    st_d  = (clr_i ? '0 : st_q) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_q <= '0;
    else if (st_ce) st_q <= st_d;
  end

  assign status_o = st_q;

endmodule

// File: rtl/updn_pos_counter.sv
module updn_pos_counter
  import updn_pos_pkg::*;
#(
  parameter int NBYTES = 4,
  localparam int CW    = 8 * NBYTES
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cnt_en_i,
  input  logic            cnt_up_i,
  input  logic            index_i,
  input  logic            wr_en_i,
  input  logic [1:0]      wr_addr_i,
  input  logic [CW-1:0]   wr_data_i,
  input  logic            host_rst_i,
  input  logic            host_load_i,
  input  logic            host_latch_i,
  input  logic            stat_clr_i,
  output logic [CW-1:0]   cnt_o,
  output logic [CW-1:0]   otr_o,
  output logic [ST_W-1:0] status_o,
  output logic            flag_o
);

  mode_a_t         mode_a;
  mode_b_t         mode_b;
  logic [CW-1:0]   data_raw;
  logic [CW-1:0]   top_mask;
  logic [CW-1:0]   cur, dtr_m;
  logic [CW-1:0]   step_nxt;
  logic            step_cy, step_bw;

  logic [CW-1:0]   cnt_q, cnt_d;
  logic [CW-1:0]   otr_q, otr_d;
  logic            halted_q, halted_d;
  logic            cnt_ce, otr_ce, halted_ce;
  logic            idx_hit, step_ok;
  logic [ST_W-1:0] st_set;
  logic [ST_W-1:0] flag_en;

  updn_pos_regs #(.CW(CW)) regs_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .mode_a_o  (mode_a),
    .mode_b_o  (mode_b),
    .data_o    (data_raw)
  );

  updn_pos_mask #(.NBYTES(NBYTES)) mask_i (
    .width_i (mode_b.width),
    .mask_o  (top_mask)
  );

  assign cur   = cnt_q & top_mask;
  assign dtr_m = data_raw & top_mask;

  updn_pos_step #(.CW(CW)) step_i (
    .mode_i   (mode_a.mode),
    .up_i     (cnt_up_i),
    .cur_i    (cur),
    .limit_i  (dtr_m),
    .top_i    (top_mask),
    .nxt_o    (step_nxt),
    .carry_o  (step_cy),
    .borrow_o (step_bw)
  );

  // Next-state: command priority host reset > host load > index load/clear > step
  always_comb begin
    idx_hit  = index_i && (mode_a.idx_act != IX_NONE);
    step_ok  = cnt_en_i && !mode_b.inhibit && !halted_q;
    cnt_d    = cur;
    halted_d = halted_q;
    st_set   = '0;
    cnt_ce   = 1'b0;

    if (host_rst_i) begin
      cnt_d    = '0;
      halted_d = 1'b0;
      cnt_ce   = 1'b1;
    end else if (host_load_i) begin
      cnt_d    = dtr_m;
      halted_d = 1'b0;
      cnt_ce   = 1'b1;
    end else if (idx_hit && (mode_a.idx_act == IX_LOAD)) begin
      cnt_d    = dtr_m;
      halted_d = 1'b0;
      cnt_ce   = 1'b1;
    end else if (idx_hit && (mode_a.idx_act == IX_CLEAR)) begin
      cnt_d    = '0;
      halted_d = 1'b0;
      cnt_ce   = 1'b1;
    end else if (step_ok) begin
      cnt_d          = step_nxt;
      cnt_ce         = 1'b1;
      st_set[ST_CY]  = step_cy;
      st_set[ST_BW]  = step_bw;
      st_set[ST_CMP] = (step_nxt != cur) && (step_nxt == dtr_m);
      if ((mode_a.mode == CM_SINGLE) && (step_cy || step_bw)) halted_d = 1'b1;
    end

    st_set[ST_IDX] = idx_hit;
    halted_ce      = (halted_d != halted_q);

    otr_ce = host_latch_i || (idx_hit && (mode_a.idx_act == IX_LATCH));
    otr_d  = cur;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      otr_q    <= '0;
      halted_q <= 1'b0;
    end else begin
      if (cnt_ce)    cnt_q    <= cnt_d;
      if (otr_ce)    otr_q    <= otr_d;
      if (halted_ce) halted_q <= halted_d;
    end
  end

  updn_pos_status status_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (st_set),
    .clr_i    (stat_clr_i),
    .status_o (status_o)
  );

  always_comb begin
    flag_en         = '0;
    flag_en[ST_IDX] = mode_b.en_idx;
    flag_en[ST_CMP] = mode_b.en_cmp;
    flag_en[ST_BW]  = mode_b.en_bw;
    flag_en[ST_CY]  = mode_b.en_cy;
  end

  assign flag_o = |(status_o & flag_en);
  assign cnt_o  = cur;
  assign otr_o  = otr_q;

endmodule

// File: rtl/updn_pos_counter_chk.sv
module updn_pos_counter_chk
  import updn_pos_pkg::*;
#(
  parameter int CW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cnt_en_i,
  input logic            cnt_up_i,
  input logic            index_i,
  input logic            wr_en_i,
  input logic            host_rst_i,
  input logic            host_load_i,
  input logic            stat_clr_i,
  input logic [CW-1:0]   cnt_o,
  input logic [ST_W-1:0] status_o,
  input cnt_mode_e       mode,
  input logic            inhibit,
  input logic            halted,
  input logic [CW-1:0]   dtr_m,
  input logic [CW-1:0]   top
);

  logic quiet;
  assign quiet = !host_rst_i && !host_load_i && !index_i && !wr_en_i;

  // R1
  p_reset_zero_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (cnt_o == '0 && status_o == '0));

  // R2
  p_free_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && cnt_en_i && cnt_up_i && !inhibit && mode == CM_FREE && cnt_o == top)
    |=> (cnt_o == '0 && status_o[ST_CY]));

  // R3
  p_single_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && cnt_en_i && halted) |=> $stable(cnt_o));

  // R4
  p_range_top_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && cnt_en_i && cnt_up_i && !inhibit && !halted && mode == CM_RANGE
     && cnt_o >= dtr_m) |=> ($stable(cnt_o) && status_o[ST_CY]));

  // R7
  p_inhibit_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && cnt_en_i && inhibit) |=> $stable(cnt_o));

  // R10
  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_clr_i |=> ((status_o & $past(status_o)) == $past(status_o)));

  // R10
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr_i && !cnt_en_i && !index_i) |=> (status_o == '0));

  // R12
  p_load_prio_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_load_i && !host_rst_i && !wr_en_i) |=> (cnt_o == $past(dtr_m)));

  // R12
  p_rst_prio_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rst_i && !wr_en_i) |=> (cnt_o == '0));

endmodule

bind updn_pos_counter updn_pos_counter_chk #(.CW(CW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cnt_en_i    (cnt_en_i),
  .cnt_up_i    (cnt_up_i),
  .index_i     (index_i),
  .wr_en_i     (wr_en_i),
  .host_rst_i  (host_rst_i),
  .host_load_i (host_load_i),
  .stat_clr_i  (stat_clr_i),
  .cnt_o       (cnt_o),
  .status_o    (status_o),
  .mode        (mode_a.mode),
  .inhibit     (mode_b.inhibit),
  .halted      (halted_q),
  .dtr_m       (dtr_m),
  .top         (top_mask)
);

// File: tb/updn_pos_counter_tb.sv
module updn_pos_counter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 5000;

  localparam logic [2:0] OP_WR    = 3'd0;
  localparam logic [2:0] OP_UP    = 3'd1;
  localparam logic [2:0] OP_DN    = 3'd2;
  localparam logic [2:0] OP_LOAD  = 3'd3;
  localparam logic [2:0] OP_RST   = 3'd4;
  localparam logic [2:0] OP_LATCH = 3'd5;
  localparam logic [2:0] OP_IDX   = 3'd6;
  localparam logic [2:0] OP_SCLR  = 3'd7;

  // control word bits for drive()
  localparam logic [7:0] C_WR = 8'h01, C_UP = 8'h02, C_DN = 8'h04, C_LOAD = 8'h08,
                         C_RST = 8'h10, C_LATCH = 8'h20, C_IDX = 8'h40, C_SCLR = 8'h80;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  addr;
    logic [31:0] data;
    logic [31:0] ecnt;
    logic [31:0] eotr;
    logic [3:0]  est;
    logic        eflag;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 45;
  // status: [3] carry [2] borrow [1] compare [0] index
  localparam vec_t VEC [NV] = '{
    '{OP_UP,   2'd0, 32'h0,  32'h1,        32'h0, 4'h0, 1'b0, 4'd2},  // R2 free up
    '{OP_DN,   2'd0, 32'h0,  32'h0,        32'h0, 4'h2, 1'b0, 4'd9},  // R9 lands on DTR=0
    '{OP_DN,   2'd0, 32'h0,  32'hFFFFFFFF, 32'h0, 4'h6, 1'b0, 4'd2},  // R2 borrow wrap
    '{OP_UP,   2'd0, 32'h0,  32'h0,        32'h0, 4'hE, 1'b0, 4'd2},  // R2 carry wrap
    '{OP_SCLR, 2'd0, 32'h0,  32'h0,        32'h0, 4'h0, 1'b0, 4'd10}, // R10
    '{OP_WR,   2'd1, 32'h03, 32'h0,        32'h0, 4'h0, 1'b0, 4'd6},  // R6 width 1 byte
    '{OP_DN,   2'd0, 32'h0,  32'hFF,       32'h0, 4'h4, 1'b0, 4'd6},  // R6
    '{OP_UP,   2'd0, 32'h0,  32'h0,        32'h0, 4'hE, 1'b0, 4'd6},  // R6
    '{OP_SCLR, 2'd0, 32'h0,  32'h0,        32'h0, 4'h0, 1'b0, 4'd10},
    '{OP_WR,   2'd2, 32'h5,  32'h0,        32'h0, 4'h0, 1'b0, 4'd5},
    '{OP_WR,   2'd1, 32'h7B, 32'h0,        32'h0, 4'h0, 1'b0, 4'd11}, // R11 enables on
    '{OP_WR,   2'd0, 32'h03, 32'h0,        32'h0, 4'h0, 1'b0, 4'd5},  // modulo
    '{OP_LOAD, 2'd0, 32'h0,  32'h5,        32'h0, 4'h0, 1'b0, 4'd12},
    '{OP_UP,   2'd0, 32'h0,  32'h0,        32'h0, 4'h8, 1'b1, 4'd5},  // R5
    '{OP_DN,   2'd0, 32'h0,  32'h5,        32'h0, 4'hE, 1'b1, 4'd5},  // R5
    '{OP_SCLR, 2'd0, 32'h0,  32'h5,        32'h0, 4'h0, 1'b0, 4'd10},
    '{OP_WR,   2'd0, 32'h02, 32'h5,        32'h0, 4'h0, 1'b0, 4'd4},  // range
    '{OP_UP,   2'd0, 32'h0,  32'h5,        32'h0, 4'h8, 1'b1, 4'd4},  // R4 hold top
    '{OP_DN,   2'd0, 32'h0,  32'h4,        32'h0, 4'h8, 1'b1, 4'd4},  // R4 resume
    '{OP_SCLR, 2'd0, 32'h0,  32'h4,        32'h0, 4'h0, 1'b0, 4'd10},
    '{OP_RST,  2'd0, 32'h0,  32'h0,        32'h0, 4'h0, 1'b0, 4'd12},
    '{OP_DN,   2'd0, 32'h0,  32'h0,        32'h0, 4'h4, 1'b1, 4'd4},  // R4 hold zero
    '{OP_UP,   2'd0, 32'h0,  32'h1,        32'h0, 4'h4, 1'b1, 4'd4},  // R4 resume
    '{OP_SCLR, 2'd0, 32'h0,  32'h1,        32'h0, 4'h0, 1'b0, 4'd10},
    '{OP_WR,   2'd0, 32'h01, 32'h1,        32'h0, 4'h0, 1'b0, 4'd3},  // single
    '{OP_DN,   2'd0, 32'h0,  32'h0,        32'h0, 4'h0, 1'b0, 4'd3},
    '{OP_DN,   2'd0, 32'h0,  32'hFF,       32'h0, 4'h4, 1'b1, 4'd3},  // R3 wrap, halt
    '{OP_DN,   2'd0, 32'h0,  32'hFF,       32'h0, 4'h4, 1'b1, 4'd3},  // R3 ignored
    '{OP_UP,   2'd0, 32'h0,  32'hFF,       32'h0, 4'h4, 1'b1, 4'd3},  // R3 ignored
    '{OP_LOAD, 2'd0, 32'h0,  32'h5,        32'h0, 4'h4, 1'b1, 4'd3},  // R3 re-enable
    '{OP_UP,   2'd0, 32'h0,  32'h6,        32'h0, 4'h4, 1'b1, 4'd3},
    '{OP_SCLR, 2'd0, 32'h0,  32'h6,        32'h0, 4'h0, 1'b0, 4'd10},
    '{OP_WR,   2'd1, 32'h7F, 32'h6,        32'h0, 4'h0, 1'b0, 4'd7},  // inhibit on
    '{OP_UP,   2'd0, 32'h0,  32'h6,        32'h0, 4'h0, 1'b0, 4'd7},  // R7 ignored
    '{OP_WR,   2'd1, 32'h7B, 32'h6,        32'h0, 4'h0, 1'b0, 4'd7},
    '{OP_WR,   2'd0, 32'h04, 32'h6,        32'h0, 4'h0, 1'b0, 4'd8},  // index load
    '{OP_IDX,  2'd0, 32'h0,  32'h5,        32'h0, 4'h1, 1'b1, 4'd8},  // R8
    '{OP_WR,   2'd0, 32'h08, 32'h5,        32'h0, 4'h1, 1'b1, 4'd8},  // index clear
    '{OP_IDX,  2'd0, 32'h0,  32'h0,        32'h0, 4'h1, 1'b1, 4'd8},  // R8
    '{OP_WR,   2'd0, 32'h0C, 32'h0,        32'h0, 4'h1, 1'b1, 4'd8},  // index latch
    '{OP_UP,   2'd0, 32'h0,  32'h1,        32'h0, 4'h1, 1'b1, 4'd2},
    '{OP_IDX,  2'd0, 32'h0,  32'h1,        32'h1, 4'h1, 1'b1, 4'd8},  // R8 snapshot
    '{OP_SCLR, 2'd0, 32'h0,  32'h1,        32'h1, 4'h0, 1'b0, 4'd10},
    '{OP_WR,   2'd0, 32'h00, 32'h1,        32'h1, 4'h0, 1'b0, 4'd8},  // index off
    '{OP_IDX,  2'd0, 32'h0,  32'h1,        32'h1, 4'h0, 1'b0, 4'd8}   // R8 no effect
  };

  logic        clk, rst_n;
  logic        cnt_en, cnt_up, index, wr_en, h_rst, h_load, h_latch, s_clr;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic [31:0] cnt, otr;
  logic [3:0]  status;
  logic        flag;

  int n_chk  = 0;
  int n_fail = 0;

  updn_pos_counter dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cnt_en_i     (cnt_en),
    .cnt_up_i     (cnt_up),
    .index_i      (index),
    .wr_en_i      (wr_en),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .host_rst_i   (h_rst),
    .host_load_i  (h_load),
    .host_latch_i (h_latch),
    .stat_clr_i   (s_clr),
    .cnt_o        (cnt),
    .otr_o        (otr),
    .status_o     (status),
    .flag_o       (flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic idle_inputs();
    cnt_en = 0; cnt_up = 0; index = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
    h_rst = 0; h_load = 0; h_latch = 0; s_clr = 0;
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic drive(input logic [7:0] ctl, input logic [1:0] a, input logic [31:0] d);
    wr_en   = ctl[0];
    cnt_en  = ctl[1] | ctl[2];
    cnt_up  = ctl[1];
    h_load  = ctl[3];
    h_rst   = ctl[4];
    h_latch = ctl[5];
    index   = ctl[6];
    s_clr   = ctl[7];
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic check(input string req, input logic [31:0] ec, input logic [31:0] eo,
                       input logic [3:0] es, input logic ef);
    n_chk++;
    if (cnt !== ec || otr !== eo || status !== es || flag !== ef) begin
      n_fail++;
      $display("FAIL %s: actual cnt=%h otr=%h st=%h flag=%b expected cnt=%h otr=%h st=%h flag=%b",
               req, cnt, otr, status, flag, ec, eo, es, ef);
    end
  endtask

  function automatic logic [7:0] op_ctl(input logic [2:0] op);
    case (op)
      OP_WR:    return C_WR;
      OP_UP:    return C_UP;
      OP_DN:    return C_DN;
      OP_LOAD:  return C_LOAD;
      OP_RST:   return C_RST;
      OP_LATCH: return C_LATCH;
      OP_IDX:   return C_IDX;
      default:  return C_SCLR;
    endcase
  endfunction

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", 32'h0, 32'h0, 4'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(op_ctl(VEC[i].op), VEC[i].addr, VEC[i].data);
      check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].ecnt, VEC[i].eotr,
            VEC[i].est, VEC[i].eflag);
    end

    // state now: free, 1 byte, enables on, DTR 5, count 1, snapshot 1
    drive(C_LOAD | C_UP, 2'd0, 32'h0);
    check("R12 load beats count strobe", 32'h5, 32'h1, 4'h0, 1'b0);
    drive(C_LATCH | C_UP, 2'd0, 32'h0);
    check("R12 snapshot takes pre-step value", 32'h6, 32'h5, 4'h0, 1'b0);
    drive(C_RST | C_DN, 2'd0, 32'h0);
    check("R12 host reset beats count strobe", 32'h0, 32'h5, 4'h0, 1'b0);
    drive(C_SCLR | C_DN, 2'd0, 32'h0);
    check("R10 event wins over same-cycle clear", 32'hFF, 32'h5, 4'h4, 1'b1);
    drive(C_SCLR, 2'd0, 32'h0);
    check("R11 flag drops after clear", 32'hFF, 32'h5, 4'h0, 1'b0);

    drive(C_WR, 2'd1, 32'h02);
    drive(C_RST, 2'd0, 32'h0);
    drive(C_DN, 2'd0, 32'h0);
    check("R6 two-byte borrow, R11 enables off", 32'hFFFF, 32'h5, 4'h4, 1'b0);
    drive(C_WR, 2'd1, 32'h01);
    check("R6 three-byte view", 32'hFFFF, 32'h5, 4'h4, 1'b0);
    drive(C_UP, 2'd0, 32'h0);
    check("R6 three-byte step past 0xFFFF", 32'h10000, 32'h5, 4'h4, 1'b0);
    drive(C_WR, 2'd1, 32'h00);
    drive(C_RST, 2'd0, 32'h0);
    drive(C_DN, 2'd0, 32'h0);
    check("R6 four-byte borrow", 32'hFFFFFFFF, 32'h5, 4'h4, 1'b0);

    // mid-run reset, then confirm cleared configuration by behaviour
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 async reset clears outputs", 32'h0, 32'h0, 4'h0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    drive(C_LOAD, 2'd0, 32'h0);
    check("R1 data value cleared", 32'h0, 32'h0, 4'h0, 1'b0);
    drive(C_DN, 2'd0, 32'h0);
    check("R1 free mode and full width after reset", 32'hFFFFFFFF, 32'h0, 4'h4, 1'b0);
    drive(C_IDX, 2'd0, 32'h0);
    check("R1 index action cleared", 32'hFFFFFFFF, 32'h0, 4'h4, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule